// File: doc/BRIEF.md
# Zero-Crossing Gated Gain Updater

This block keeps the active gain for a left and a right audio channel and decides when a requested gain change takes effect. A change asked for by the host controller, or by the recovery step of an automatic level loop, is held as a pending value. It is applied only when that channel's own sample stream passes through zero, or when a programmable timeout runs out, whichever happens first. Moving the gain at a zero crossing avoids audible clicks. The timeout caps how long a quiet or DC-offset signal can hold a change back.

Each channel is gated on its own. The left channel may commit while the right is still waiting. Reductions ordered by the limiter are urgent and bypass the gate completely. Level detection, and the calculation of the gain values themselves, take place outside this block.

Top module: `zcg_gain_updater`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both `gain` entries equal the parameter `RESET_GAIN` and both `busy` bits are 0.
- R2: `to_sel` chooses the timeout as a number of sample strobes. With `rate48`=0 the codes 00/01/10/11 give 256/512/2048/16384. With `rate48`=1 they give 384/768/3072/24576. Each count is shifted right by the parameter `TO_SHIFT`, with a minimum of 1.
- R3: A zero crossing on a channel is a strobed sample exactly equal to 0, or a strobed sample whose sign bit differs from the sign bit of the previous strobed sample. After reset, the previous sign counts as non-negative.
- R4: A channel with a pending value commits that value on a strobe cycle that is a zero crossing. The new `gain` is visible on the following cycle. A request accepted on a crossing strobe commits in that same cycle.
- R5: If no crossing occurs, a pending value commits on the Nth strobe (N from R2). The strobe in the accepting cycle is counted as the first.
- R6: Index 0 is left and index 1 is right. Each channel accepts requests, detects crossings, times out and commits independently of the other.
- R7: Host requests (`host_req`) and recovery requests (`rec_req`) are both gated. If both arrive on one channel in the same cycle, the host value is used.
- R8: A gated request that arrives while a channel is pending replaces the pending value and does not restart that channel's timeout count.
- R9: A limiter request (`lim_req`) sets `gain` to `lim_gain` on the next cycle, regardless of crossings. It takes priority over gated requests in the same cycle and discards any pending value.
- R10: `busy` of a channel is 1 from the cycle after a gated request is accepted until the cycle after it commits or is discarded. A request that commits in its own cycle never raises `busy`.
- R11: Samples on cycles with `smp_stb` low neither count toward the timeout nor update the stored previous sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe marking a valid sample pair |
| rate48 | input | 1 | Rate select: 0 = 32 kHz timing, 1 = 48 kHz timing |
| smp_l | input | SAMPLE_W | Left sample, two's complement |
| smp_r | input | SAMPLE_W | Right sample, two's complement |
| to_sel | input | 2 | Timeout code |
| host_req | input | 2 | Per-channel host gain request |
| host_gain | input | 2 x GAIN_W | Per-channel host gain value |
| rec_req | input | 2 | Per-channel recovery gain request |
| rec_gain | input | 2 x GAIN_W | Per-channel recovery gain value |
| lim_req | input | 2 | Per-channel limiter gain request |
| lim_gain | input | 2 x GAIN_W | Per-channel limiter gain value |
| gain | output | 2 x GAIN_W | Committed gain per channel |
| busy | output | 2 | Per-channel pending flag |

## Verification
The bench builds the block with `TO_SHIFT` = 4, 8-bit gains and 16-bit samples. This reduces the longest timeout from 24576 to 1536 strobes. As a result, all eight rate and code combinations can be run to full expiry and their exact strobe counts checked. Crossing, replacement, priority and limiter cases are driven with explicit sample values. Gains and busy flags are compared against a behavioural model on every clock.

// File: rtl/zcg_pkg.sv
package zcg_pkg;

    localparam int unsigned TO_MAX = 24576;
    localparam int          CNT_W  = $clog2(TO_MAX + 1);

    typedef enum logic [1:0] {
        TO_SHORT = 2'b00,
        TO_MID   = 2'b01,
        TO_LONG  = 2'b10,
        TO_MAXC  = 2'b11
    } to_code_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_HOST,
        SRC_REC,
        SRC_LIM
    } gain_src_e;

    // Timeout in strobes; 48 kHz timing uses 1.5x the 32 kHz count.
    function automatic logic [CNT_W-1:0] to_limit(input logic rate48,
                                                  input logic [1:0] code,
                                                  input int shift);
        logic [31:0] base;
        case (to_code_e'(code))
            TO_SHORT: base = 32'd256;
            TO_MID:   base = 32'd512;
            TO_LONG:  base = 32'd2048;
            default:  base = 32'd16384;
        endcase
        if (rate48) base = base + (base >> 1);
        base = base >> shift;
        if (base == 32'd0) base = 32'd1;
        return base[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/zcg_zero_detect.sv
module zcg_zero_detect #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                zc
);
    logic prev_neg;

    assign zc = stb & ((sample == '0) | (sample[SAMPLE_W-1] != prev_neg));

    always_ff @(posedge clk) begin
        if (rst)      prev_neg <= 1'b0;
        else if (stb) prev_neg <= sample[SAMPLE_W-1];
    end
endmodule

// File: rtl/zcg_channel.sv
module zcg_channel
    import zcg_pkg::*;
#(
    parameter int          GAIN_W     = 8,
    parameter int          SAMPLE_W   = 16,
    parameter int          TO_SHIFT   = 0,
    parameter logic [GAIN_W-1:0] RESET_GAIN = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic                rate48,
    input  logic [1:0]          to_sel,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                host_req,
    input  logic [GAIN_W-1:0]   host_gain,
    input  logic                rec_req,
    input  logic [GAIN_W-1:0]   rec_gain,
    input  logic                lim_req,
    input  logic [GAIN_W-1:0]   lim_gain,
    output logic [GAIN_W-1:0]   gain,
    output logic                busy
);
    logic              zc;
    logic [CNT_W-1:0]  limit;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_base;
    logic [CNT_W:0]    cnt_nxt;
    logic [GAIN_W-1:0] pend;
    logic [GAIN_W-1:0] pend_nxt;
    logic              accept;
    logic              armed;
    logic              hit;
    gain_src_e         src;

    zcg_zero_detect #(.SAMPLE_W(SAMPLE_W)) u_zd (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .sample (sample),
        .zc     (zc)
    );

    assign limit = to_limit(rate48, to_sel, TO_SHIFT);

    always_comb begin
        if (lim_req)       src = SRC_LIM;
        else if (host_req) src = SRC_HOST;
        else if (rec_req)  src = SRC_REC;
        else               src = SRC_NONE;
    end

    assign accept   = (src == SRC_HOST) || (src == SRC_REC);
    assign pend_nxt = (src == SRC_HOST) ? host_gain :
                      (src == SRC_REC)  ? rec_gain  : pend;
    assign armed    = busy | accept;
    assign cnt_base = busy ? cnt : '0;
    assign cnt_nxt  = {1'b0, cnt_base} + {{CNT_W{1'b0}}, 1'b1};
    assign hit      = zc | (cnt_nxt >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            gain <= RESET_GAIN;
            busy <= 1'b0;
            pend <= RESET_GAIN;
            cnt  <= '0;
        end else if (src == SRC_LIM) begin
            gain <= lim_gain;
            busy <= 1'b0;
            cnt  <= '0;
        end else if (armed) begin
            if (stb && hit) begin
                gain <= pend_nxt;
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                busy <= 1'b1;
                pend <= pend_nxt;
                cnt  <= stb ? cnt_nxt[CNT_W-1:0] : cnt_base;
            end
        end
    end
endmodule

// File: rtl/zcg_gain_updater.sv
module zcg_gain_updater #(
    parameter int                GAIN_W     = 8,
    parameter int                SAMPLE_W   = 16,
    parameter int                TO_SHIFT   = 0,
    parameter logic [GAIN_W-1:0] RESET_GAIN = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_stb,
    input  logic                  rate48,
    input  logic [SAMPLE_W-1:0]   smp_l,
    input  logic [SAMPLE_W-1:0]   smp_r,
    input  logic [1:0]            to_sel,
    input  logic [1:0]            host_req,
    input  logic [1:0][GAIN_W-1:0] host_gain,
    input  logic [1:0]            rec_req,
    input  logic [1:0][GAIN_W-1:0] rec_gain,
    input  logic [1:0]            lim_req,
    input  logic [1:0][GAIN_W-1:0] lim_gain,
    output logic [1:0][GAIN_W-1:0] gain,
    output logic [1:0]            busy
);
    localparam int N_CH = 2;

    logic [N_CH-1:0][SAMPLE_W-1:0] smp;
    assign smp[0] = smp_l;
    assign smp[1] = smp_r;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        zcg_channel #(
            .GAIN_W     (GAIN_W),
            .SAMPLE_W   (SAMPLE_W),
            .TO_SHIFT   (TO_SHIFT),
            .RESET_GAIN (RESET_GAIN)
        ) u_ch (
            .clk       (clk),
            .rst       (rst),
            .stb       (smp_stb),
            .rate48    (rate48),
            .to_sel    (to_sel),
            .sample    (smp[c]),
            .host_req  (host_req[c]),
            .host_gain (host_gain[c]),
            .rec_req   (rec_req[c]),
            .rec_gain  (rec_gain[c]),
            .lim_req   (lim_req[c]),
            .lim_gain  (lim_gain[c]),
            .gain      (gain[c]),
            .busy      (busy[c])
        );
    end
endmodule

// File: rtl/zcg_checker.sv
module zcg_checker #(
    parameter int GAIN_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   smp_stb,
    input logic [1:0]             host_req,
    input logic [1:0]             rec_req,
    input logic [1:0]             lim_req,
    input logic [1:0][GAIN_W-1:0] lim_gain,
    input logic [1:0][GAIN_W-1:0] gain,
    input logic [1:0]             busy
);
    for (genvar c = 0; c < 2; c++) begin : g_chk
        // R9: limiter value lands on the next cycle and clears pending
        a_r9_limiter_immediate: assert property (@(posedge clk) disable iff (rst)
            lim_req[c] |=> (gain[c] == $past(lim_gain[c])) && !busy[c]);

        // R11: no strobe and no limiter means a pending channel stays pending
        a_r11_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
            busy[c] && !smp_stb && !lim_req[c] |=> busy[c]);

        // R4: a gated commit happens only on a strobe cycle
        a_r4_commit_on_strobe: assert property (@(posedge clk) disable iff (rst)
            $fell(busy[c]) |-> $past(smp_stb || lim_req[c]));

        // R10: busy rises only after a gated request
        a_r10_busy_needs_request: assert property (@(posedge clk) disable iff (rst)
            $rose(busy[c]) |-> $past(host_req[c] || rec_req[c]));

        // R6: gain of an idle channel with no request of its own does not move
        a_r6_idle_gain_stable: assert property (@(posedge clk) disable iff (rst)
            !busy[c] && !host_req[c] && !rec_req[c] && !lim_req[c] |=> $stable(gain[c]));
    end
endmodule

bind zcg_gain_updater zcg_checker #(.GAIN_W(GAIN_W)) u_zcg_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .host_req (host_req),
    .rec_req  (rec_req),
    .lim_req  (lim_req),
    .lim_gain (lim_gain),
    .gain     (gain),
    .busy     (busy)
);

// File: tb/zcg_gain_updater_bench.sv
module zcg_gain_updater_bench;
    localparam int GW = 8;
    localparam int SW = 16;
    localparam int SH = 4;
    localparam logic [GW-1:0] RG = 8'h40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_stb = 1'b0;
    logic rate48 = 1'b0;
    logic [SW-1:0] smp_l = '0;
    logic [SW-1:0] smp_r = '0;
    logic [1:0] to_sel = 2'b00;
    logic [1:0] host_req = '0, rec_req = '0, lim_req = '0;
    logic [1:0][GW-1:0] host_gain = '0, rec_gain = '0, lim_gain = '0;
    logic [1:0][GW-1:0] gain;
    logic [1:0] busy;

    always #2 clk = ~clk;

    zcg_gain_updater #(.GAIN_W(GW), .SAMPLE_W(SW), .TO_SHIFT(SH), .RESET_GAIN(RG)) u_zcg_gain_updater (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .rate48(rate48),
        .smp_l(smp_l), .smp_r(smp_r), .to_sel(to_sel),
        .host_req(host_req), .host_gain(host_gain),
        .rec_req(rec_req), .rec_gain(rec_gain),
        .lim_req(lim_req), .lim_gain(lim_gain),
        .gain(gain), .busy(busy)
    );

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit done = 0;

    int mg[2], mb[2], mp[2], mc[2], mneg[2];

    function automatic int ref_limit(bit r48, int code);
        int v;
        if (!r48) v = (code == 0) ? 256 : (code == 1) ? 512 : (code == 2) ? 2048 : 16384;
        else      v = (code == 0) ? 384 : (code == 1) ? 768 : (code == 2) ? 3072 : 24576;
        v = v >> SH;
        return (v < 1) ? 1 : v;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            mg[c] = RG; mb[c] = 0; mp[c] = RG; mc[c] = 0; mneg[c] = 0;
        end
    endtask

    task automatic model_step();
        for (int c = 0; c < 2; c++) begin
            int s, pv, cn;
            bit zc, acc;
            s  = (c == 0) ? int'($signed(smp_l)) : int'($signed(smp_r));
            zc = smp_stb && (s == 0 || ((s < 0) ? 1 : 0) != mneg[c]);
            if (smp_stb) mneg[c] = (s < 0) ? 1 : 0;
            if (lim_req[c]) begin
                mg[c] = lim_gain[c]; mb[c] = 0; mc[c] = 0;
            end else begin
                acc = host_req[c] || rec_req[c];
                pv  = host_req[c] ? int'(host_gain[c]) : rec_req[c] ? int'(rec_gain[c]) : mp[c];
                cn  = mb[c] ? mc[c] : 0;
                if (mb[c] || acc) begin
                    if (smp_stb && (zc || cn + 1 >= ref_limit(rate48, to_sel))) begin
                        mg[c] = pv; mb[c] = 0; mc[c] = 0;
                    end else begin
                        mb[c] = 1; mp[c] = pv; mc[c] = cn + (smp_stb ? 1 : 0);
                    end
                end
            end
        end
    endtask

    task automatic compare();
        for (int c = 0; c < 2; c++) begin
            chk(tag, int'(gain[c]), mg[c]);
            chk(tag, int'(busy[c]), mb[c]);
        end
    endtask

    // inputs are driven after a negedge; tick advances one clock and compares
    task automatic tick();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        @(negedge clk);
        compare();
        host_req = '0; rec_req = '0; lim_req = '0;
    endtask

    task automatic samp(int l, int r);
        smp_l = SW'(l); smp_r = SW'(r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        model_reset();
        tick(); tick();
        chk("R1", int'(gain[0]), RG); chk("R1", int'(gain[1]), RG);
        chk("R1", int'(busy), 0);
        rst = 1'b0;
        smp_stb = 1'b1;
        samp(100, 100);
        tick();
        chk("R1", int'(gain[1]), RG);

        // R2 / R5: full expiry for every rate and code, strobe every cycle
        tag = "R5";
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 4; k++) begin
                rate48 = r[0]; to_sel = k[1:0];
                host_req[0] = 1'b1; host_gain[0] = GW'(16 * r + k + 1);
                tick(); n = 1;
                while (busy[0] && n < 5000) begin tick(); n++; end
                chk("R2", n, ref_limit(r[0], k));
                chk("R5", int'(gain[0]), 16 * r + k + 1);
            end
        end

        // R4 / R6: left crosses while right stays positive
        tag = "R4"; rate48 = 1'b0; to_sel = 2'b11;
        host_req = 2'b11; host_gain[0] = 8'h11; host_gain[1] = 8'h22;
        tick();
        chk("R10", int'(busy), 3);
        samp(-5, 100); tick();
        chk("R4", int'(gain[0]), 8'h11); chk("R4", int'(busy[0]), 0);
        chk("R6", int'(busy[1]), 1); chk("R6", int'(gain[1]), RG);
        samp(-5, -7); tick();
        chk("R6", int'(gain[1]), 8'h22); chk("R10", int'(busy[1]), 0);

        // R3: exact zero from a negative history
        tag = "R3";
        host_req[0] = 1'b1; host_gain[0] = 8'h33; tick();
        chk("R3", int'(busy[0]), 1);
        samp(0, -7); tick();
        chk("R3", int'(gain[0]), 8'h33);
        samp(-3, -7); tick();

        // R11: unstrobed positive sample is ignored
        tag = "R11";
        host_req[0] = 1'b1; host_gain[0] = 8'h44; tick();
        smp_stb = 1'b0; samp(50, -7);
        repeat (3) tick();
        chk("R11", int'(busy[0]), 1); chk("R11", int'(gain[0]), 8'h33);
        smp_stb = 1'b1; samp(-5, -7); tick();
        chk("R11", int'(busy[0]), 1);
        samp(50, -7); tick();
        chk("R11", int'(gain[0]), 8'h44);

        // R7: host wins over recovery, recovery alone is gated
        tag = "R7";
        host_req[0] = 1'b1; host_gain[0] = 8'h55; rec_req[0] = 1'b1; rec_gain[0] = 8'h66;
        tick();
        samp(-2, -7); tick();
        chk("R7", int'(gain[0]), 8'h55);
        rec_req[0] = 1'b1; rec_gain[0] = 8'h77; tick();
        chk("R7", int'(busy[0]), 1); chk("R7", int'(gain[0]), 8'h55);
        samp(9, -7); tick();
        chk("R7", int'(gain[0]), 8'h77);

        // R8: replacement keeps the original deadline
        tag = "R8"; to_sel = 2'b00;
        host_req[0] = 1'b1; host_gain[0] = 8'h88; tick(); n = 1;
        repeat (4) begin tick(); n++; end
        host_req[0] = 1'b1; host_gain[0] = 8'h99; tick(); n++;
        while (busy[0] && n < 100) begin tick(); n++; end
        chk("R8", n, ref_limit(1'b0, 0)); chk("R8", int'(gain[0]), 8'h99);

        // R9: limiter overrides a pending value and a same-cycle host request
        tag = "R9"; to_sel = 2'b11;
        host_req[0] = 1'b1; host_gain[0] = 8'hAA; tick();
        lim_req[0] = 1'b1; lim_gain[0] = 8'h0B; host_req[0] = 1'b1; host_gain[0] = 8'hCC;
        tick();
        chk("R9", int'(gain[0]), 8'h0B); chk("R9", int'(busy[0]), 0);
        samp(-9, -7); tick();
        chk("R9", int'(gain[0]), 8'h0B);

        // R4: request accepted on a crossing strobe commits at once
        tag = "R4";
        host_req[1] = 1'b1; host_gain[1] = 8'h5A; samp(-9, 4); tick();
        chk("R10", int'(busy[1]), 0); chk("R4", int'(gain[1]), 8'h5A);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule